// File: doc/BRIEF.md
# Byte-Lane Nonvolatile RAM Core

This block is a clock-synchronous behavioural model of a 16-bit word memory with an asynchronous-SRAM-style control set. The controls are all active low: chip select, write strobe, output gate, and one enable for each byte lane. Each cycle the core samples these controls. From them it works out which mode applies: deselected, read, write, or outputs off. That mode becomes a per-lane write strobe and a per-lane output drive enable. The data buses are split into an upper byte (bits 15:8) and a lower byte (bits 7:0). Each lane has its own input, its own output and its own tri-state enable, so that pad drivers outside the block can be wired directly.

A supply monitor input stops all access while the supply is reported bad. Once the supply returns, access stays blocked for a fixed number of clock cycles. This lockout applies both at first power-up and after every brownout. The storage has no reset, so its contents survive both reset and loss of the supply-good flag, as a nonvolatile part would. The full-size configuration uses a 16-bit address (65,536 words). The default build is smaller, so that elaboration stays light.

Top module: `nvram_core`

## Requirements
- R1: A word written with both byte enables low can be read back in full from the same address. The upper byte is on the upper lane and the lower byte is on the lower lane.
- R2: While chip select is high, neither lane is driven and nothing is written, whatever the other controls are.
- R3: A read is a sampled cycle with chip select low, write strobe high and output gate low. One cycle later, each lane whose byte enable was low has its drive enable high and carries the stored byte.
- R4: A lane that is not driven has its drive enable low and its data output at zero. This covers a lane whose byte enable is high, and both lanes when the output gate is high.
- R5: A write is a sampled cycle with chip select and write strobe both low. It updates only the lanes whose byte enable is low, and the output gate has no effect on it.
- R6: While the supply-good input is low, no write changes the storage and no lane is driven.
- R7: After supply-good is sampled high on STARTUP_CYC consecutive clock edges following reset or a supply drop, access is allowed from the next edge. Earlier edges behave as in R6.
- R8: In any cycle whose write strobe is low, both lanes are undriven in the following cycle, even when the output gate is low.
- R9: Stored contents are kept through a synchronous reset and through a supply drop with its startup lockout.
- R10: During and right after reset, both drive enables and both data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (storage is not cleared) |
| supply_ok | input | 1 | High while the supply is above the write-inhibit level |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| ub_n | input | 1 | Upper byte enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| addr | input | ADDR_W | Word address |
| dq_hi_in | input | 8 | Upper byte write data |
| dq_lo_in | input | 8 | Lower byte write data |
| dq_hi_out | output | 8 | Upper byte read data, zero when not driven |
| dq_lo_out | output | 8 | Lower byte read data, zero when not driven |
| dq_hi_oe | output | 1 | Upper lane drive enable |
| dq_lo_oe | output | 1 | Lower lane drive enable |

## Verification
The bench builds the core with ADDR_W = 4 and STARTUP_CYC = 5. With 16 words it can write every address, then apply all 32 combinations of the five control inputs at each address, and then read each word back. Every mode of the decode therefore meets every address. The five-cycle lockout lets the bench probe each edge of the startup window, both after reset and after a brownout, and then confirm that the contents written before the drop are still there.

// File: rtl/nvr_pkg.sv
// Package: shared constants and the operation type for the nonvolatile RAM core.
// Assumes a 16-bit word split into two 8-bit lanes; lane 0 is bits 7:0.
package nvr_pkg;
    localparam int LANE_W    = 8;
    localparam int NUM_LANES = 2;
    localparam int WORD_W    = LANE_W * NUM_LANES;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } nvr_op_e;
endpackage

// File: rtl/nvr_supply_gate.sv
// Module: startup lockout after the supply returns.
// Access is allowed once supply_ok has been sampled high on STARTUP_CYC
// consecutive edges since reset or since the last drop.
// Assumes STARTUP_CYC >= 1.
module nvr_supply_gate #(
    parameter int STARTUP_CYC = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic access_ok
);
    localparam int CNT_W = $clog2(STARTUP_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STARTUP_CYC);

    logic [CNT_W-1:0] wait_cnt;

    // Reload on reset or supply loss; otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok) begin
            wait_cnt <= CNT_LOAD;
        end else if (wait_cnt != '0) begin
            wait_cnt <= wait_cnt - 1'b1;
        end
    end

    // Access needs a good supply and an expired lockout.
    assign access_ok = supply_ok && (wait_cnt == '0);

    initial begin
        if (STARTUP_CYC < 1) $error("STARTUP_CYC must be at least 1");
    end

    // R7: on the first good sample after a drop the lockout is still running.
    a_r7_rise_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_ok) |-> !access_ok);

    // R7: the counter never exceeds its load value.
    a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= CNT_LOAD);

    // R6: access is granted only when the supply was also good one edge earlier.
    a_r6_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
        access_ok |-> $past(supply_ok));
endmodule

// File: rtl/nvr_mode_decode.sv
// Module: decodes the active-low control set into per-lane read and write strobes.
// Purely combinational; access_ok comes from the supply gate.
module nvr_mode_decode
    import nvr_pkg::*;
#(
    parameter int LANES = NUM_LANES
) (
    input  logic             access_ok,
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [LANES-1:0] be_n,
    output logic [LANES-1:0] lane_rd,
    output logic [LANES-1:0] lane_wr
);
    nvr_op_e op;

    // Choose the word-level operation from chip select, write strobe and gate.
    always_comb begin
        op = OP_IDLE;
        if (access_ok && !ce_n) begin
            if (!we_n)      op = OP_WRITE;
            else if (!oe_n) op = OP_READ;
        end
    end

    // Each lane joins the operation only when its own byte enable is low.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_rd[g] = (op == OP_READ)  && !be_n[g];
        assign lane_wr[g] = (op == OP_WRITE) && !be_n[g];
    end
endmodule

// File: rtl/nvr_lane_bank.sv
// Module: storage and registered output for one byte lane.
// The array has no reset so that its contents persist. The output stage
// registers the read byte and its drive enable; undriven data reads zero.
module nvr_lane_bank #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              drive
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Array write; nonvolatile, so it is never cleared.
    always_ff @(posedge clk) begin
        if (wr) mem[addr] <= wdata;
    end

    // Output register: the read byte and its drive enable, zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive <= 1'b0;
            rdata <= '0;
        end else begin
            drive <= rd;
            rdata <= rd ? mem[addr] : '0;
        end
    end

    // R4: a lane not selected for reading is quiet on the next cycle.
    a_r4_idle_lane_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (!drive && rdata == '0));

    // R5: a lane cannot be read and written in the same cycle.
    a_r5_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && wr));
endmodule

// File: rtl/nvram_core.sv
// Module: top of the byte-lane nonvolatile RAM core.
// Samples the control set every clock, applies the supply lockout, and
// drives two lanes (0 = bits 7:0, 1 = bits 15:8) with registered outputs.
// Default ADDR_W is reduced; set ADDR_W = 16 for the full 64K-word array.
module nvram_core
    import nvr_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int STARTUP_CYC = 200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_hi_in,
    input  logic [7:0]        dq_lo_in,
    output logic [7:0]        dq_hi_out,
    output logic [7:0]        dq_lo_out,
    output logic              dq_hi_oe,
    output logic              dq_lo_oe
);
    logic                 access_ok;
    logic [NUM_LANES-1:0] be_n;
    logic [NUM_LANES-1:0] lane_rd;
    logic [NUM_LANES-1:0] lane_wr;
    logic [WORD_W-1:0]    wword;
    logic [WORD_W-1:0]    rword;
    logic [NUM_LANES-1:0] drive;

    assign be_n  = {ub_n, lb_n};
    assign wword = {dq_hi_in, dq_lo_in};

    nvr_supply_gate #(
        .STARTUP_CYC(STARTUP_CYC)
    ) gate_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .access_ok (access_ok)
    );

    nvr_mode_decode #(
        .LANES(NUM_LANES)
    ) dec_i (
        .access_ok (access_ok),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .be_n      (be_n),
        .lane_rd   (lane_rd),
        .lane_wr   (lane_wr)
    );

    // One storage bank per byte lane.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_bank
        nvr_lane_bank #(
            .ADDR_W(ADDR_W),
            .DATA_W(LANE_W)
        ) bank_i (
            .clk   (clk),
            .rst_n (rst_n),
            .addr  (addr),
            .wr    (lane_wr[g]),
            .rd    (lane_rd[g]),
            .wdata (wword[g*LANE_W +: LANE_W]),
            .rdata (rword[g*LANE_W +: LANE_W]),
            .drive (drive[g])
        );
    end

    assign dq_lo_out = rword[LANE_W-1:0];
    assign dq_hi_out = rword[WORD_W-1:LANE_W];
    assign dq_lo_oe  = drive[0];
    assign dq_hi_oe  = drive[1];

    // R2: a deselected cycle leaves both lanes undriven.
    a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!dq_hi_oe && !dq_lo_oe));

    // R8: a cycle with the write strobe low never drives the lanes.
    a_r8_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> (!dq_hi_oe && !dq_lo_oe));

    // R6: with the supply bad, outputs stay undriven on the next cycle.
    a_r6_no_read_when_bad: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!dq_hi_oe && !dq_lo_oe));

    // R4: each lane follows its own byte enable.
    a_r4_upper_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ub_n |=> !dq_hi_oe);
    a_r4_lower_gated: assert property (@(posedge clk) disable iff (!rst_n)
        lb_n |=> !dq_lo_oe);

    // R10: the cycle after reset is held shows quiet outputs.
    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!dq_hi_oe && !dq_lo_oe && dq_hi_out == 8'h00 && dq_lo_out == 8'h00));
endmodule

// File: tb/nvram_core_tb.sv
// Bench: exhaustive control sweep over a 16-word core with a 5-cycle lockout.
module nvram_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 4;
    localparam int NSTART     = 5;
    localparam int WORDS      = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          supply_ok = 1'b1;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    hi_in = '0, lo_in = '0;
    logic [7:0]    hi_out, lo_out;
    logic          hi_oe, lo_oe;

    logic [15:0]   ref_mem [WORDS];
    int            good_run = 0;
    int            n_vec = 0;
    int            n_bad = 0;
    logic [15:0]   lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvram_core #(
        .ADDR_W(AW),
        .STARTUP_CYC(NSTART)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n),
        .addr(addr), .dq_hi_in(hi_in), .dq_lo_in(lo_in),
        .dq_hi_out(hi_out), .dq_lo_out(lo_out),
        .dq_hi_oe(hi_oe), .dq_lo_oe(lo_oe)
    );

    function automatic logic [15:0] next_rand(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // Tag for a sweep cycle from the mode it exercises.
    function automatic string mode_tag(input logic c, input logic w, input logic o,
                                       input logic u, input logic l);
        if (c) return "R2";
        if (!w) return "R8";
        if (o || (u && l)) return "R4";
        return "R3";
    endfunction

    // Apply one cycle, update the reference, and compare the registered outputs.
    task automatic step(input logic r, input logic s, input logic c, input logic w,
                        input logic o, input logic u, input logic l,
                        input logic [AW-1:0] a, input logic [15:0] d, input string tag);
        logic       allow, rd;
        logic [7:0] e_hi, e_lo;
        logic       e_hoe, e_loe;
        @(negedge clk);
        rst_n = r; supply_ok = s; ce_n = c; we_n = w; oe_n = o; ub_n = u; lb_n = l;
        addr = a; hi_in = d[15:8]; lo_in = d[7:0];
        allow = r && s && (good_run >= NSTART);
        rd    = allow && !c && w && !o;
        e_loe = rd && !l;
        e_hoe = rd && !u;
        e_lo  = e_loe ? ref_mem[a][7:0]  : 8'h00;
        e_hi  = e_hoe ? ref_mem[a][15:8] : 8'h00;
        @(posedge clk);
        if (allow && !c && !w) begin
            if (!l) ref_mem[a][7:0]  = d[7:0];
            if (!u) ref_mem[a][15:8] = d[15:8];
        end
        if (!r || !s) good_run = 0;
        else if (good_run < NSTART) good_run++;
        #(CLK_PERIOD/4);
        n_vec++;
        if ({hi_oe, lo_oe, hi_out, lo_out} !== {e_hoe, e_loe, e_hi, e_lo}) begin
            n_bad++;
            $display("FAIL %s addr=%0d got oe=%b%b data=%h%h expected oe=%b%b data=%h%h",
                     tag, a, hi_oe, lo_oe, hi_out, lo_out, e_hoe, e_loe, e_hi, e_lo);
        end
    endtask

    task automatic read_word(input logic [AW-1:0] a, input string tag);
        step(1, 1, 0, 1, 0, 0, 0, a, 16'h0000, tag);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stimulus
        // R10: reset holds outputs quiet.
        for (int i = 0; i < 3; i++) step(0, 1, 0, 1, 0, 0, 0, '0, 16'h0, "R10");

        // R7: startup window after reset; reads and a write are refused until it ends.
        step(1, 1, 0, 0, 1, 0, 0, 4'd3, 16'hDEAD, "R7");
        for (int i = 0; i < NSTART + 1; i++) step(1, 1, 0, 1, 0, 0, 0, 4'd3, 16'h0, "R7");

        // R1: fill every word with both lanes enabled, then read them back.
        for (int a = 0; a < WORDS; a++) begin
            lfsr = next_rand(lfsr);
            step(1, 1, 0, 0, a[0], 0, 0, AW'(a), lfsr, "R1");
        end
        for (int a = 0; a < WORDS; a++) read_word(AW'(a), "R1");

        // R2 R3 R4 R5 R8: every control combination at every address.
        for (int a = 0; a < WORDS; a++) begin
            for (int m = 0; m < 32; m++) begin
                lfsr = next_rand(lfsr);
                step(1, 1, m[4], m[3], m[2], m[1], m[0], AW'(a), lfsr,
                     mode_tag(m[4], m[3], m[2], m[1], m[0]));
            end
            read_word(AW'(a), "R5");
        end

        // R6: supply bad; writes and reads are blocked.
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0, 4'd5, 16'h1234, "R6");
        step(1, 0, 0, 1, 0, 0, 0, 4'd5, 16'h0, "R6");

        // R7: lockout after the brownout, then an upper-only write.
        for (int i = 0; i < NSTART; i++) step(1, 1, 0, 0, 1, 0, 1, 4'd6, 16'hBEEF, "R7");
        step(1, 1, 0, 0, 1, 0, 1, 4'd6, 16'hC0DE, "R7");
        read_word(4'd6, "R5");

        // R9: contents survive the brownout and a reset.
        for (int a = 0; a < WORDS; a++) read_word(AW'(a), "R9");
        step(0, 1, 1, 1, 1, 1, 1, '0, 16'h0, "R10");
        for (int i = 0; i < NSTART; i++) step(1, 1, 0, 1, 0, 0, 0, '0, 16'h0, "R7");
        for (int a = 0; a < WORDS; a++) read_word(AW'(a), "R9");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule